// File: doc/BRIEF.md
# Register Rename Status File

This block is an architectural register file whose entries each carry a pending flag and a writer tag. The tag names the in-flight instruction that is due to produce the next value of that register. An issue stage uses it in two ways. It looks up two source registers and gets back, for each one, either a usable value or the tag of the producer it must wait for. It also records the tag of the issuing instruction as the new writer of that instruction's destination.

The file snoops a single result broadcast bus. A register takes the broadcast value only when the broadcast tag equals its own recorded writer tag. When a newer instruction has already claimed a register, the result of an older producer is dropped there. That older result still reaches its waiting consumers over the bus, because the consumers hold the tag and not the register name. A source lookup that hits a tag being broadcast in the same cycle returns the broadcast value directly.

Top module: `rsf_status_file`

## Requirements
- R1: After reset every register is not pending and holds value 0, so any lookup reports ready with data 0 and tag 0.
- R2: A lookup of a register that is not pending reports ready=1, data equal to the stored value and tag 0.
- R3: A lookup of a pending register, with no matching broadcast in that cycle, reports ready=0, tag equal to the recorded writer tag and data 0.
- R4: An issue with valid set makes its destination register pending with the issuing tag, seen by lookups from the next cycle.
- R5: A broadcast whose tag equals a pending register's writer tag stores the broadcast data and clears pending, seen from the next cycle.
- R6: A broadcast whose tag differs from a register's current writer tag changes neither its value, its pending flag nor its tag. This covers an older producer whose write was cancelled by a newer writer.
- R7: When an issue names a register in the same cycle as a broadcast that matches that register's writer, the register ends pending with the new issue tag.
- R8: A lookup of a pending register whose writer tag matches a broadcast in the same cycle reports ready=1 with the broadcast data.
- R9: Lookups in the cycle of an issue see the state before that issue, including when a source names the issue's own destination.
- R10: With issue valid low, the issue destination and tag have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a_idx | input | IDX_W | Register index for lookup port A |
| src_a_ready | output | 1 | Port A value is usable |
| src_a_data | output | DATA_W | Port A value when ready, else 0 |
| src_a_tag | output | TAG_W | Port A pending writer tag when not ready, else 0 |
| src_b_idx | input | IDX_W | Register index for lookup port B |
| src_b_ready | output | 1 | Port B value is usable |
| src_b_data | output | DATA_W | Port B value when ready, else 0 |
| src_b_tag | output | TAG_W | Port B pending writer tag when not ready, else 0 |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | IDX_W | Destination register of the issuing instruction |
| iss_tag | input | TAG_W | Tag of the issuing instruction |
| bus_valid | input | 1 | A result is broadcast this cycle |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_data | input | DATA_W | Broadcast result value |

## Verification
A wrong pending flag or writer tag inside the file shows on the lookup ports as a wrong ready bit, a stale tag or a missing value. This appears in the first cycle a source names that register. A failed cancellation shows one cycle after the stale broadcast: the register reads back as ready with the old producer's data instead of waiting on the newer tag. The stimulus therefore reads every touched register both in the broadcast cycle, to check the bypass, and in the cycle after, to check the stored state.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
   // Outcome of one source lookup.
   typedef enum logic {
      SRC_WAIT  = 1'b0,
      SRC_READY = 1'b1
   } src_kind_e;
endpackage

// File: rtl/rsf_entry.sv
module rsf_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim,
   input  logic [TAG_W-1:0]  claim_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   output logic              pend_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] val_o
);
   logic              pend_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              snoop_hit;

   assign snoop_hit = bus_valid && pend_q && (tag_q == bus_tag);

   // A new claim wins over a completing producer in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= '0;
      end else if (claim) begin
         pend_q <= 1'b1;
         tag_q  <= claim_tag;
      end else if (snoop_hit) begin
         pend_q <= 1'b0;
         val_q  <= bus_data;
      end
   end

   assign pend_o = pend_q;
   assign tag_o  = tag_q;
   assign val_o  = val_q;
endmodule

// File: rtl/rsf_read_port.sv
module rsf_read_port
   import rsf_pkg::*;
#(
   parameter int NUM_REGS  = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 5,
   parameter bit BYPASS_EN = 1'b1,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]                 idx,
   input  logic [NUM_REGS-1:0]              pend_vec,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_arr,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_arr,
   input  logic                             bus_valid,
   input  logic [TAG_W-1:0]                 bus_tag,
   input  logic [DATA_W-1:0]                bus_data,
   output src_kind_e                        kind,
   output logic [DATA_W-1:0]                data,
   output logic [TAG_W-1:0]                 tag
);
   logic              sel_pend;
   logic [TAG_W-1:0]  sel_tag;
   logic [DATA_W-1:0] sel_val;

   assign sel_pend = pend_vec[idx];
   assign sel_tag  = tag_arr[idx];
   assign sel_val  = val_arr[idx];

   generate
      if (BYPASS_EN) begin : g_bypass
         logic fwd;
         assign fwd = sel_pend && bus_valid && (sel_tag == bus_tag);
         always_comb begin
            if (!sel_pend) begin
               kind = SRC_READY;
               data = sel_val;
               tag  = '0;
            end else if (fwd) begin
               kind = SRC_READY;
               data = bus_data;
               tag  = '0;
            end else begin
               kind = SRC_WAIT;
               data = '0;
               tag  = sel_tag;
            end
         end
      end else begin : g_plain
         always_comb begin
            kind = sel_pend ? SRC_WAIT : SRC_READY;
            data = sel_pend ? '0 : sel_val;
            tag  = sel_pend ? sel_tag : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/rsf_status_file.sv
module rsf_status_file
   import rsf_pkg::*;
#(
   parameter int NUM_REGS  = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 5,
   parameter bit BYPASS_EN = 1'b1,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  src_a_idx,
   output logic              src_a_ready,
   output logic [DATA_W-1:0] src_a_data,
   output logic [TAG_W-1:0]  src_a_tag,
   input  logic [IDX_W-1:0]  src_b_idx,
   output logic              src_b_ready,
   output logic [DATA_W-1:0] src_b_data,
   output logic [TAG_W-1:0]  src_b_tag,
   input  logic              iss_valid,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data
);
   generate
      if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
         $error("NUM_REGS must be a power of two, at least 2");
      end
      if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("DATA_W and TAG_W must be positive");
      end
   endgenerate

   logic [NUM_REGS-1:0]             pend_q;
   logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_q;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         rsf_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (iss_valid && (iss_dst == IDX_W'(i))),
            .claim_tag (iss_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .pend_o    (pend_q[i]),
            .tag_o     (tag_q[i]),
            .val_o     (val_q[i])
         );
      end
   endgenerate

   src_kind_e kind_a, kind_b;

   rsf_read_port #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS_EN(BYPASS_EN)
   ) u_port_a (
      .idx(src_a_idx), .pend_vec(pend_q), .tag_arr(tag_q), .val_arr(val_q),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .kind(kind_a), .data(src_a_data), .tag(src_a_tag)
   );

   rsf_read_port #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS_EN(BYPASS_EN)
   ) u_port_b (
      .idx(src_b_idx), .pend_vec(pend_q), .tag_arr(tag_q), .val_arr(val_q),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .kind(kind_b), .data(src_b_data), .tag(src_b_tag)
   );

   assign src_a_ready = (kind_a == SRC_READY);
   assign src_b_ready = (kind_b == SRC_READY);
endmodule

// File: rtl/rsf_status_file_chk.sv
module rsf_status_file_chk #(
   parameter int NUM_REGS  = 16,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 5,
   parameter bit BYPASS_EN = 1'b1,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [IDX_W-1:0]                 src_a_idx,
   input logic                             src_a_ready,
   input logic [DATA_W-1:0]                src_a_data,
   input logic [TAG_W-1:0]                 src_a_tag,
   input logic                             iss_valid,
   input logic [IDX_W-1:0]                 iss_dst,
   input logic [TAG_W-1:0]                 iss_tag,
   input logic                             bus_valid,
   input logic [TAG_W-1:0]                 bus_tag,
   input logic [DATA_W-1:0]                bus_data,
   input logic [NUM_REGS-1:0]              pend_q,
   input logic [NUM_REGS-1:0][TAG_W-1:0]   tag_q,
   input logic [NUM_REGS-1:0][DATA_W-1:0]  val_q
);
   logic a_pend, a_fwd, a_claim;
   assign a_pend  = pend_q[src_a_idx];
   assign a_fwd   = a_pend && bus_valid && (tag_q[src_a_idx] == bus_tag);
   assign a_claim = iss_valid && (iss_dst == src_a_idx);

   a_r2_ready_value: assert property (@(posedge clk) disable iff (!rst_n)
      !a_pend |-> (src_a_ready && src_a_data == val_q[src_a_idx]));

   a_r3_wait_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (a_pend && !a_fwd) |-> (!src_a_ready && src_a_tag == tag_q[src_a_idx]));

   a_r4_issue_claims: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> (pend_q[$past(iss_dst)] && tag_q[$past(iss_dst)] == $past(iss_tag)));

   a_r5_match_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (a_fwd && !a_claim) |=>
         (!pend_q[$past(src_a_idx)] && val_q[$past(src_a_idx)] == $past(bus_data)));

   a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && a_pend && tag_q[src_a_idx] != bus_tag && !a_claim) |=>
         (pend_q[$past(src_a_idx)] &&
          tag_q[$past(src_a_idx)] == $past(tag_q[src_a_idx]) &&
          val_q[$past(src_a_idx)] == $past(val_q[src_a_idx])));

   a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS_EN && a_fwd) |-> (src_a_ready && src_a_data == bus_data));
endmodule

bind rsf_status_file rsf_status_file_chk #(
   .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS_EN(BYPASS_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .src_a_idx(src_a_idx), .src_a_ready(src_a_ready),
   .src_a_data(src_a_data), .src_a_tag(src_a_tag),
   .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
   .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
   .pend_q(pend_q), .tag_q(tag_q), .val_q(val_q)
);

// File: tb/rsf_status_file_tb.sv
module rsf_status_file_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 8;
   localparam int DW = 16;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    src_a_idx = '0, src_b_idx = '0;
   logic          src_a_ready, src_b_ready;
   logic [DW-1:0] src_a_data, src_b_data;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic          iss_valid = 1'b0;
   logic [2:0]    iss_dst = '0;
   logic [TW-1:0] iss_tag = '0;
   logic          bus_valid = 1'b0;
   logic [TW-1:0] bus_tag = '0;
   logic [DW-1:0] bus_data = '0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsf_status_file #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .BYPASS_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_data(src_a_data), .src_a_tag(src_a_tag),
      .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_data(src_b_data), .src_b_tag(src_b_tag),
      .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
   );

   typedef struct packed {
      logic          iv;
      logic [2:0]    dst;
      logic [TW-1:0] itag;
      logic          bv;
      logic [TW-1:0] btag;
      logic [DW-1:0] bdata;
      logic [2:0]    ai;
      logic [2:0]    bi;
      logic          ar;
      logic [DW-1:0] aexp;
      logic          br;
      logic [DW-1:0] bexp;
      logic [7:0]    req;
   } vec_t;

   // exp field: data when ready, writer tag when waiting.
   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd3,3'd5,1'b1,16'h0000,1'b1,16'h0000,8'd1},  // R1
      '{1'b1,3'd2,4'd5,1'b0,4'd0,16'h0000,3'd2,3'd2,1'b1,16'h0000,1'b1,16'h0000,8'd9},  // R9
      '{1'b1,3'd4,4'd6,1'b0,4'd0,16'h0000,3'd2,3'd4,1'b0,16'h0005,1'b1,16'h0000,8'd4},  // R4 R3
      '{1'b0,3'd0,4'd0,1'b1,4'd5,16'h1111,3'd2,3'd4,1'b1,16'h1111,1'b0,16'h0006,8'd8},  // R8
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd2,3'd4,1'b1,16'h1111,1'b0,16'h0006,8'd5},  // R5 R2
      '{1'b1,3'd4,4'd7,1'b0,4'd0,16'h0000,3'd4,3'd2,1'b0,16'h0006,1'b1,16'h1111,8'd3},  // R3
      '{1'b0,3'd0,4'd0,1'b1,4'd6,16'h2222,3'd4,3'd2,1'b0,16'h0007,1'b1,16'h1111,8'd6},  // R6
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd4,3'd2,1'b0,16'h0007,1'b1,16'h1111,8'd6},  // R6
      '{1'b1,3'd4,4'd8,1'b1,4'd7,16'h3333,3'd4,3'd4,1'b1,16'h3333,1'b1,16'h3333,8'd7},  // R7
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd4,3'd0,1'b0,16'h0008,1'b1,16'h0000,8'd7},  // R7
      '{1'b0,3'd0,4'd9,1'b0,4'd0,16'h0000,3'd0,3'd0,1'b1,16'h0000,1'b1,16'h0000,8'd10}, // R10
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd0,3'd4,1'b1,16'h0000,1'b0,16'h0008,8'd10}, // R10
      '{1'b0,3'd0,4'd0,1'b1,4'd8,16'h4444,3'd4,3'd2,1'b1,16'h4444,1'b1,16'h1111,8'd8},  // R8
      '{1'b0,3'd0,4'd0,1'b0,4'd0,16'h0000,3'd4,3'd2,1'b1,16'h4444,1'b1,16'h1111,8'd5}   // R5
   };

   task automatic check_port(input string nm, input int req, input logic rdy,
                             input logic [DW-1:0] data, input logic [TW-1:0] tag,
                             input logic erdy, input logic [DW-1:0] eval);
      logic [DW-1:0] got;
      got = rdy ? data : DW'(tag);
      total++;
      if (rdy !== erdy || got !== eval) begin
         bad++;
         $display("FAIL R%0d port %s: ready=%0b val=%h expected ready=%0b val=%h",
                  req, nm, rdy, got, erdy, eval);
      end
   endtask

   task automatic idle_inputs();
      iss_valid = 1'b0; iss_dst = '0; iss_tag = '0;
      bus_valid = 1'b0; bus_tag = '0; bus_data = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         iss_valid = TBL[i].iv;  iss_dst = TBL[i].dst; iss_tag = TBL[i].itag;
         bus_valid = TBL[i].bv;  bus_tag = TBL[i].btag; bus_data = TBL[i].bdata;
         src_a_idx = TBL[i].ai;  src_b_idx = TBL[i].bi;
         #1;
         check_port("A", int'(TBL[i].req), src_a_ready, src_a_data, src_a_tag, TBL[i].ar, TBL[i].aexp);
         check_port("B", int'(TBL[i].req), src_b_ready, src_b_data, src_b_tag, TBL[i].br, TBL[i].bexp);
      end

      // R1: claim a register, then reset; all state returns to ready with 0.
      @(negedge clk);
      idle_inputs();
      iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 4'd3;
      @(negedge clk);
      idle_inputs();
      src_a_idx = 3'd2; src_b_idx = 3'd4;
      #1;
      check_port("A", 3, src_a_ready, src_a_data, src_a_tag, 1'b0, 16'h0003);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_port("A", 1, src_a_ready, src_a_data, src_a_tag, 1'b1, 16'h0000);
      check_port("B", 1, src_b_ready, src_b_data, src_b_tag, 1'b1, 16'h0000);

      // R6: a broadcast with the pre-reset tag must not revive or alter reg 2.
      @(negedge clk);
      bus_valid = 1'b1; bus_tag = 4'd3; bus_data = 16'h5555;
      @(negedge clk);
      idle_inputs();
      #1;
      check_port("A", 6, src_a_ready, src_a_data, src_a_tag, 1'b1, 16'h0000);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule